// File: doc/BRIEF.md
# Burst Offset Generator

This block produces the two low-order address bits that a synchronous burst memory uses during a four-beat burst. A new burst begins when an address strobe is qualified. At that clock edge the two low bits of the external address become the start offset, and the beat count clears. Each later cycle with the advance input asserted moves the block to the next beat. After the fourth beat the count wraps back to the start offset. It never carries into the upper address bits, and those bits stay outside the block.

The block supports two beat orders. The interleaved order suits processor-style cache line fills: the offset is the start value XOR the beat count. The linear order adds the beat count to the start value, modulo four. A parameter can fix the order at build time, or it can hand the choice to the `order_il` pin. The block also flags the last beat of the four, so the memory controller knows when the burst ends.

Two strobes exist. The controller strobe always qualifies. The processor strobe qualifies only while chip select is asserted. A qualified load always wins over a concurrent advance.

Top module: `burst_offset_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the start value and the beat count, so `ofs` reads 0 and `last_beat` reads 0 after that edge, even if a strobe or advance is asserted in the same cycle.
- R2: With `ctl_stb_n` low at a rising edge, `addr_lo` is loaded as the start value and the beat count clears, whatever the state of `sel_n`. After that edge `ofs` equals the loaded value and `last_beat` is 0.
- R3: With `cpu_stb_n` low and `sel_n` low at a rising edge, the block loads `addr_lo` in the same way as R2.
- R4: While `sel_n` is high, `cpu_stb_n` has no effect. An edge with `adv_n` low still steps the beat, and an edge with `adv_n` high holds `ofs`.
- R5: In any cycle where a strobe qualifies, `adv_n` is ignored. After the edge `ofs` equals the new start value, not the value one beat later.
- R6: In interleaved order (`order_il` = 1 when the pin selects the order), the offset for beat b from start s is s XOR b. For example, start 01 gives 01, 00, 11, 10.
- R7: In linear order (`order_il` = 0), the offset for beat b from start s is (s + b) mod 4. For example, start 11 gives 11, 00, 01, 10.
- R8: `last_beat` is 1 exactly while the beat count is 3, which is the fourth offset. One more advance wraps `ofs` back to the start value and clears `last_beat`.
- R9: With no qualified strobe and `adv_n` high, `ofs` and `last_beat` keep their values over any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Chip select, active low; gates the processor strobe |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_il | input | 1 | Order select when the order is a pin: 1 interleaved, 0 linear |
| addr_lo | input | OFS_W | Low bits of the external address, loaded as the start offset |
| ofs | output | OFS_W | Current burst offset |
| last_beat | output | 1 | High on the fourth beat of the burst |

## Verification
Both state registers feed `ofs` through combinational mapping only, so a wrong start value or a wrong beat count shows at the ports right after the edge that produced it. A start value that was loaded wrongly, or that a deselected processor strobe corrupted, is wrong on the first beat. A beat count that steps wrongly shows a wrong offset in the next cycle. It also moves `last_beat` onto the wrong beat, and the wrap then fails to return to the start value. Running all four start values in both orders covers every start and beat combination, so each error of this kind is caught within at most five cycles of its cause.

// File: rtl/burst_pkg.sv
package burst_pkg;

   typedef enum logic [1:0] {
      ORD_LINEAR     = 2'd0,
      ORD_INTERLEAVE = 2'd1,
      ORD_PIN        = 2'd2
   } order_e;

endpackage

// File: rtl/burst_load_qual.sv
module burst_load_qual (
   input  logic sel_n,
   input  logic cpu_stb_n,
   input  logic ctl_stb_n,
   input  logic adv_n,
   output logic load,
   output logic step
);
   // controller strobe always qualifies; processor strobe needs chip select
   always_comb begin
      load = !ctl_stb_n || (!cpu_stb_n && !sel_n);
      step = !load && !adv_n;
   end
endmodule

// File: rtl/burst_beat_reg.sv
module burst_beat_reg #(
   parameter int OFS_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             step,
   input  logic [OFS_W-1:0] load_val,
   output logic [OFS_W-1:0] start_q,
   output logic [OFS_W-1:0] beat_q
);
   localparam logic [OFS_W-1:0] ZERO = '0;
   localparam logic [OFS_W-1:0] ONE  = {{(OFS_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (rst) begin
         start_q <= ZERO;
         beat_q  <= ZERO;
      end else if (load) begin
         start_q <= load_val;
         beat_q  <= ZERO;
      end else if (step) begin
         beat_q  <= beat_q + ONE;   // natural wrap, no carry out
      end
   end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
   parameter int              OFS_W = 2,
   parameter burst_pkg::order_e ORDER = burst_pkg::ORD_PIN
) (
   input  logic             order_il,
   input  logic [OFS_W-1:0] start_q,
   input  logic [OFS_W-1:0] beat_q,
   output logic [OFS_W-1:0] ofs
);
   logic [OFS_W-1:0] lin_v;
   logic [OFS_W-1:0] il_v;

   always_comb begin
      lin_v = start_q + beat_q;
      il_v  = start_q ^ beat_q;
   end

   generate
      if (ORDER == burst_pkg::ORD_LINEAR) begin : g_lin
         logic unused_sel;
         assign unused_sel = order_il;
         assign ofs = lin_v;
      end else if (ORDER == burst_pkg::ORD_INTERLEAVE) begin : g_il
         logic unused_sel;
         assign unused_sel = order_il;
         assign ofs = il_v;
      end else begin : g_pin
         assign ofs = order_il ? il_v : lin_v;
      end
   endgenerate
endmodule

// File: rtl/burst_offset_gen.sv
module burst_offset_gen #(
   parameter int                OFS_W = 2,
   parameter burst_pkg::order_e ORDER = burst_pkg::ORD_PIN
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sel_n,
   input  logic             cpu_stb_n,
   input  logic             ctl_stb_n,
   input  logic             adv_n,
   input  logic             order_il,
   input  logic [OFS_W-1:0] addr_lo,
   output logic [OFS_W-1:0] ofs,
   output logic             last_beat
);
   localparam int BEATS = 1 << OFS_W;

   generate
      if (OFS_W < 1 || OFS_W > 6) begin : g_bad_width
         $error("burst_offset_gen: OFS_W must be 1..6");
      end
      if (BEATS < 2) begin : g_bad_beats
         $error("burst_offset_gen: a burst needs at least two beats");
      end
   endgenerate

   logic             load;
   logic             step;
   logic [OFS_W-1:0] start_q;
   logic [OFS_W-1:0] beat_q;

   burst_load_qual u_qual (
      .sel_n     (sel_n),
      .cpu_stb_n (cpu_stb_n),
      .ctl_stb_n (ctl_stb_n),
      .adv_n     (adv_n),
      .load      (load),
      .step      (step)
   );

   burst_beat_reg #(.OFS_W(OFS_W)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .step     (step),
      .load_val (addr_lo),
      .start_q  (start_q),
      .beat_q   (beat_q)
   );

   burst_order_map #(.OFS_W(OFS_W), .ORDER(ORDER)) u_map (
      .order_il (order_il),
      .start_q  (start_q),
      .beat_q   (beat_q),
      .ofs      (ofs)
   );

   assign last_beat = &beat_q;
endmodule

// File: rtl/burst_offset_chk.sv
module burst_offset_chk #(
   parameter int OFS_W = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             sel_n,
   input logic             cpu_stb_n,
   input logic             ctl_stb_n,
   input logic             adv_n,
   input logic             order_il,
   input logic [OFS_W-1:0] addr_lo,
   input logic [OFS_W-1:0] ofs,
   input logic             last_beat
);
   logic rst_seen_q;
   always_ff @(posedge clk) rst_seen_q <= rst;

   // R1: state is zero once a reset edge has passed
   always @(negedge clk) begin
      if (rst_seen_q == 1'b1) begin
         a_r1_reset_zero : assert (ofs == '0 && !last_beat);
      end
   end

   a_r2_ctl_load : assert property (@(posedge clk) disable iff (rst)
      !ctl_stb_n |=> (ofs == $past(addr_lo) && !last_beat));

   a_r3_cpu_load : assert property (@(posedge clk) disable iff (rst)
      (!cpu_stb_n && !sel_n) |=> (ofs == $past(addr_lo) && !last_beat));

   // R4 / R9: an unqualified processor strobe with no advance changes nothing
   a_r4_cpu_ignored : assert property (@(posedge clk) disable iff (rst)
      (ctl_stb_n && sel_n && adv_n) |=>
         ($stable(last_beat) && ((order_il != $past(order_il)) || $stable(ofs))));

   a_r8_wrap_clears : assert property (@(posedge clk) disable iff (rst)
      (last_beat && ctl_stb_n && (cpu_stb_n || sel_n) && !adv_n) |=> !last_beat);
endmodule

bind burst_offset_gen burst_offset_chk #(.OFS_W(OFS_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .sel_n     (sel_n),
   .cpu_stb_n (cpu_stb_n),
   .ctl_stb_n (ctl_stb_n),
   .adv_n     (adv_n),
   .order_il  (order_il),
   .addr_lo   (addr_lo),
   .ofs       (ofs),
   .last_beat (last_beat)
);

// File: tb/sim_burst_offset_gen.sv
`timescale 1ns/1ps
module sim_burst_offset_gen;
   logic       clk = 1'b0;
   logic       rst;
   logic       sel_n, cpu_stb_n, ctl_stb_n, adv_n, order_il;
   logic [1:0] addr_lo;
   logic [1:0] ofs;
   logic       last_beat;
   int         n_chk  = 0;
   int         n_fail = 0;

   always #4 clk = ~clk;   // 125 MHz

   burst_offset_gen #(.OFS_W(2), .ORDER(burst_pkg::ORD_PIN)) u0 (
      .clk(clk), .rst(rst), .sel_n(sel_n), .cpu_stb_n(cpu_stb_n),
      .ctl_stb_n(ctl_stb_n), .adv_n(adv_n), .order_il(order_il),
      .addr_lo(addr_lo), .ofs(ofs), .last_beat(last_beat)
   );

   function automatic logic [1:0] model(input logic il, input logic [1:0] s,
                                        input logic [1:0] b);
      return il ? (s ^ b) : 2'((s + b) & 2'b11);
   endfunction

   task automatic chk(input string req, input logic [1:0] got_o, input logic [1:0] exp_o,
                      input logic got_l, input logic exp_l);
      n_chk++;
      if (got_o !== exp_o || got_l !== exp_l) begin
         n_fail++;
         $display("FAIL %s: ofs=%0d last=%0b expected ofs=%0d last=%0b",
                  req, got_o, got_l, exp_o, exp_l);
      end
   endtask

   // drive at falling edge, sample 1 ns after the next rising edge
   task automatic cyc(input logic r, input logic sl, input logic cpu, input logic ctl,
                      input logic adv, input logic [1:0] a);
      @(negedge clk);
      rst = r; sel_n = sl; cpu_stb_n = cpu; ctl_stb_n = ctl; adv_n = adv; addr_lo = a;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      cyc(1, 0, 0, 0, 0, 2'd3);
      chk("R1 reset with strobe", ofs, 2'd0, last_beat, 1'b0);
      cyc(0, 1, 1, 1, 0, 2'd0);
      cyc(0, 1, 1, 1, 0, 2'd0);
      cyc(1, 1, 1, 1, 1, 2'd0);
      chk("R1 reset mid burst", ofs, 2'd0, last_beat, 1'b0);
   endtask

   task automatic t_burst(input logic il, input logic [1:0] s);
      order_il = il;
      cyc(0, 0, 1, 0, 1, s);
      chk(il ? "R6 first beat" : "R7 first beat", ofs, s, last_beat, 1'b0);
      for (int b = 1; b < 4; b++) begin
         cyc(0, 0, 1, 1, 0, 2'd0);
         chk(il ? "R6 beat R8 flag" : "R7 beat R8 flag",
             ofs, model(il, s, 2'(b)), last_beat, b == 3);
      end
      cyc(0, 0, 1, 1, 0, 2'd0);
      chk("R8 wrap to start", ofs, s, last_beat, 1'b0);
   endtask

   task automatic t_cpu_gate();
      order_il = 1'b0;
      cyc(0, 0, 1, 0, 1, 2'd2);
      cyc(0, 1, 0, 1, 1, 2'd1);
      chk("R4 deselected strobe holds", ofs, 2'd2, last_beat, 1'b0);
      cyc(0, 1, 0, 1, 0, 2'd1);
      chk("R4 deselected strobe, advance steps", ofs, 2'd3, last_beat, 1'b0);
      cyc(0, 0, 0, 1, 1, 2'd1);
      chk("R3 processor strobe loads", ofs, 2'd1, last_beat, 1'b0);
   endtask

   task automatic t_ctl_desel();
      order_il = 1'b1;
      cyc(0, 0, 1, 0, 1, 2'd0);
      cyc(0, 1, 1, 0, 1, 2'd2);
      chk("R2 controller strobe loads while deselected", ofs, 2'd2, last_beat, 1'b0);
   endtask

   task automatic t_priority();
      order_il = 1'b0;
      cyc(0, 0, 1, 0, 1, 2'd0);
      cyc(0, 0, 1, 1, 0, 2'd0);
      cyc(0, 0, 1, 1, 0, 2'd0);
      cyc(0, 0, 1, 0, 0, 2'd3);
      chk("R5 load beats advance (ctl)", ofs, 2'd3, last_beat, 1'b0);
      cyc(0, 0, 0, 1, 0, 2'd1);
      chk("R5 load beats advance (cpu)", ofs, 2'd1, last_beat, 1'b0);
   endtask

   task automatic t_hold();
      order_il = 1'b1;
      cyc(0, 0, 1, 0, 1, 2'd1);
      cyc(0, 0, 1, 1, 0, 2'd0);
      cyc(0, 0, 1, 1, 0, 2'd0);
      cyc(0, 0, 1, 1, 0, 2'd0);
      for (int i = 0; i < 5; i++) begin
         cyc(0, i[0], 1, 1, 1, 2'(i));
         chk("R9 hold on last beat", ofs, 2'd2, last_beat, 1'b1);
      end
   endtask

   initial begin
      #100000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst = 1; sel_n = 1; cpu_stb_n = 1; ctl_stb_n = 1; adv_n = 1;
      order_il = 0; addr_lo = 0;
      t_reset();
      for (int m = 0; m < 2; m++)
         for (int s = 0; s < 4; s++)
            t_burst(m[0], 2'(s));
      t_cpu_gate();
      t_ctl_desel();
      t_priority();
      t_hold();
      t_reset();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule